// File: doc/BRIEF.md
# Chained 32-bit Countdown Timer

This block is a general-purpose countdown timer made from two 16-bit halves that are chained into one 32-bit down-counter. Software reaches it through a simple word-addressed register port. The port carries a configuration register, two per-half mode registers, a control register, the interval value (written as one 32-bit word or upper half only), the live count, and a set of interrupt registers: raw status, mask, masked status and clear.

Once started, the counter loads the interval and counts down by one on each clock. At zero it flags a timeout and reloads. In periodic mode it keeps running. In one-shot mode it stops and drops its own run bit. A timeout latches a raw status bit, which drives a level interrupt through a mask. When the trigger enable is set, a timeout also produces a one-cycle trigger pulse. A stall bit freezes the count. A new interval written while the timer runs takes over the count at once.

Register offsets (word addresses): 0 config, 1 lower mode, 2 upper mode, 3 control, 4 interval (32-bit), 5 interval upper half, 6 count (32-bit), 7 count upper half, 8 raw status, 9 mask, 10 masked status, 11 clear. Offsets 12 to 15 read as zero.

Top module: `chain_timer`

## Requirements
- R1: After reset, the interval and count both read 0xFFFF_FFFF, and every other register reads 0. The interrupt output and the trigger output are both low.
- R2: A write to offset 4 stores wrData[31:16] in the upper interval half and wrData[15:0] in the lower half. Offset 4 reads back as {upper, lower}. A write to offset 5 replaces only the upper half, taking it from wrData[15:0]. Offset 5 reads that half in bits [15:0].
- R3: Offset 6 reads the count as {upper half, lower half}. Offset 7 reads the upper half of the count in bits [15:0].
- R4: Writing control bit 0 (run) from 0 to 1 loads the count from the interval at that clock edge. At every later edge, while running, not stalled, config 0 and count nonzero, the count drops by exactly one, with the borrow passing from the lower half to the upper half.
- R5: When the count is 0 while the timer is counting, that cycle is a timeout, and the next edge reloads the interval. If lower mode bits [1:0] equal 2 (periodic), run stays set, so the timeout period is interval+1 cycles.
- R6: If lower mode bits [1:0] hold any value other than 2 (one-shot), a timeout clears control bit 0, and the count then holds the reloaded value. A control write in the same cycle takes priority over this clear.
- R7: The upper mode register (offset 2, bits [1:0]) is stored and can be read back, but it has no effect on counting.
- R8: A timeout sets raw status bit 0 (offset 8). The bit stays set until a write to offset 11 with bit 0 set. Writing 0 there leaves the bit unchanged. If a timeout and a clear fall in the same cycle, the bit stays set.
- R9: Masked status bit 0 (offset 10) equals raw bit 0 AND mask bit 0 (offset 9). The irq output equals that masked bit.
- R10: With control bit 2 set, trigOut is high in exactly the timeout cycles. With bit 2 clear, trigOut stays low.
- R11: While run is set, a write to offset 4 or 5 loads the count with the new interval at that same edge, even while stalled. While run is clear, such a write leaves the count unchanged.
- R12: While control bit 1 (stall) is set, the count holds and no timeout occurs. Counting resumes once the bit is cleared.
- R13: Config bits [2:0] (offset 0) read back as written. Any value other than 0 (reserved) stops counting and timeouts.
- R14: An interval of 0 gives a timeout on every counting cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Word address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt (masked timeout) |
| trigOut | output | 1 | One-cycle trigger pulse on timeout |

## Verification
The bench builds the block with its defaults: 16-bit halves and a 4-bit address. The random traffic keeps intervals below 24, so timeouts, one-shot stops, stall windows and same-cycle clear/timeout collisions occur hundreds of times within a few thousand cycles. At this size the upper half stays at zero in random traffic. A directed interval of 0x0001_0002 is therefore used to carry a borrow across the half boundary. A directed upper-half write checks that the two halves load separately.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;

  // Word offsets of the register port
  localparam int REG_CFG      = 0;
  localparam int REG_MODE_LO  = 1;
  localparam int REG_MODE_HI  = 2;
  localparam int REG_CTRL     = 3;
  localparam int REG_LOAD     = 4;
  localparam int REG_LOAD_HI  = 5;
  localparam int REG_COUNT    = 6;
  localparam int REG_COUNT_HI = 7;
  localparam int REG_RAW      = 8;
  localparam int REG_MASK     = 9;
  localparam int REG_MASKED   = 10;
  localparam int REG_CLEAR    = 11;

  localparam logic [1:0] MODE_PERIODIC = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLo;        // write lower interval half
    logic wrHi;        // write upper interval half
    logic hiFromUpper; // upper half takes data from the upper word bits
    logic cntLoad;     // counter takes the (next) interval value
    logic cntDec;      // counter decrements by one
  } dp_strobe_t;

endpackage

// File: rtl/chain_timer_dp.sv
module chain_timer_dp
  import chain_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int NUM_HALVES = 2,
  localparam int DATA_W = NUM_HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              cntZero
);

  logic [NUM_HALVES-1:0] borrow;
  logic [NUM_HALVES-1:0] halfZero;

  assign borrow[0] = 1'b1;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] loadQ;
    logic [HALF_W-1:0] cntQ;
    logic [HALF_W-1:0] wrSlice;
    logic [HALF_W-1:0] loadNext;
    logic              wrHalf;

    if (h == 0) begin : g_lo
      assign wrSlice = wrData[HALF_W-1:0];
      assign wrHalf  = strobe.wrLo;
    end else begin : g_hi
      assign wrSlice = strobe.hiFromUpper ? wrData[h*HALF_W +: HALF_W]
                                          : wrData[HALF_W-1:0];
      assign wrHalf  = strobe.wrHi;
    end

    // The new interval is forwarded so a write and a load can share an edge
    assign loadNext = wrHalf ? wrSlice : loadQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadQ <= '1;
        cntQ  <= '1;
      end else begin
        loadQ <= loadNext;
        if (strobe.cntLoad) begin
          cntQ <= loadNext;
        end else if (strobe.cntDec && borrow[h]) begin
          cntQ <= cntQ - HALF_W'(1);
        end
      end
    end

    assign halfZero[h] = (cntQ == '0);

    if (h < NUM_HALVES - 1) begin : g_borrow
      assign borrow[h+1] = borrow[h] && halfZero[h];
    end

    assign loadVal[h*HALF_W +: HALF_W]  = loadQ;
    assign countVal[h*HALF_W +: HALF_W] = cntQ;
  end

  assign cntZero = &halfZero;

endmodule

// File: rtl/chain_timer_ctrl.sv
module chain_timer_ctrl
  import chain_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 4,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        wrLow,
  input  logic              cntZero,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] countVal,
  output dp_strobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              trigOut,
  output logic              irq,
  output logic              runBit,
  output logic              stallBit,
  output logic [2:0]        cfgSel,
  output logic              periodicMode,
  output logic              rawBit,
  output logic              maskBit,
  output logic              timeoutEvt,
  output logic              loadWrite,
  output logic              ctrlWrite
);

  logic [2:0] cfgQ;
  logic [1:0] modeLoQ;
  logic [1:0] modeHiQ;
  logic       runQ;
  logic       stallQ;
  logic       trigEnQ;
  logic       rawQ;
  logic       maskQ;

  logic wrLoadFull;
  logic wrLoadUpper;
  logic clearHit;
  logic counting;
  logic enableRise;

  assign ctrlWrite   = wrEn && (int'(addr) == REG_CTRL);
  assign wrLoadFull  = wrEn && (int'(addr) == REG_LOAD);
  assign wrLoadUpper = wrEn && (int'(addr) == REG_LOAD_HI);
  assign loadWrite   = wrLoadFull || wrLoadUpper;
  assign clearHit    = wrEn && (int'(addr) == REG_CLEAR) && wrLow[0];

  assign counting     = runQ && !stallQ && (cfgQ == 3'd0);
  assign timeoutEvt   = counting && cntZero;
  assign enableRise   = ctrlWrite && wrLow[0] && !runQ;
  assign periodicMode = (modeLoQ == MODE_PERIODIC);

  always_comb begin
    strobe             = '0;
    strobe.wrLo        = wrLoadFull;
    strobe.wrHi        = loadWrite;
    strobe.hiFromUpper = wrLoadFull;
    strobe.cntLoad     = enableRise || (runQ && loadWrite) || timeoutEvt;
    strobe.cntDec      = counting && !cntZero && !strobe.cntLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      modeLoQ <= '0;
      modeHiQ <= '0;
      runQ    <= 1'b0;
      stallQ  <= 1'b0;
      trigEnQ <= 1'b0;
      rawQ    <= 1'b0;
      maskQ   <= 1'b0;
    end else begin
      if (wrEn && (int'(addr) == REG_CFG))     cfgQ    <= wrLow;
      if (wrEn && (int'(addr) == REG_MODE_LO)) modeLoQ <= wrLow[1:0];
      if (wrEn && (int'(addr) == REG_MODE_HI)) modeHiQ <= wrLow[1:0];
      if (wrEn && (int'(addr) == REG_MASK))    maskQ   <= wrLow[0];

      if (ctrlWrite) begin
        runQ    <= wrLow[0];
        stallQ  <= wrLow[1];
        trigEnQ <= wrLow[2];
      end else if (timeoutEvt && !periodicMode) begin
        runQ <= 1'b0;
      end

      rawQ <= (clearHit ? 1'b0 : rawQ) | timeoutEvt;
    end
  end

  always_comb begin
    rdData = '0;
    case (int'(addr))
      REG_CFG:      rdData[2:0] = cfgQ;
      REG_MODE_LO:  rdData[1:0] = modeLoQ;
      REG_MODE_HI:  rdData[1:0] = modeHiQ;
      REG_CTRL:     rdData[2:0] = {trigEnQ, stallQ, runQ};
      REG_LOAD:     rdData      = loadVal;
      REG_LOAD_HI:  rdData[HALF_W-1:0] = loadVal[DATA_W-1:HALF_W];
      REG_COUNT:    rdData      = countVal;
      REG_COUNT_HI: rdData[HALF_W-1:0] = countVal[DATA_W-1:HALF_W];
      REG_RAW:      rdData[0]   = rawQ;
      REG_MASK:     rdData[0]   = maskQ;
      REG_MASKED:   rdData[0]   = rawQ && maskQ;
      default:      rdData      = '0;
    endcase
  end

  assign trigOut  = timeoutEvt && trigEnQ;
  assign irq      = rawQ && maskQ;
  assign runBit   = runQ;
  assign stallBit = stallQ;
  assign cfgSel   = cfgQ;
  assign rawBit   = rawQ;
  assign maskBit  = maskQ;

endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import chain_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 4,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              trigOut
);

  dp_strobe_t        strobe;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] countVal;
  logic              cntZero;
  logic              runBit;
  logic              stallBit;
  logic [2:0]        cfgSel;
  logic              periodicMode;
  logic              rawBit;
  logic              maskBit;
  logic              timeoutEvt;
  logic              loadWrite;
  logic              ctrlWrite;

  chain_timer_ctrl #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .addr         (addr),
    .wrLow        (wrData[2:0]),
    .cntZero      (cntZero),
    .loadVal      (loadVal),
    .countVal     (countVal),
    .strobe       (strobe),
    .rdData       (rdData),
    .trigOut      (trigOut),
    .irq          (irq),
    .runBit       (runBit),
    .stallBit     (stallBit),
    .cfgSel       (cfgSel),
    .periodicMode (periodicMode),
    .rawBit       (rawBit),
    .maskBit      (maskBit),
    .timeoutEvt   (timeoutEvt),
    .loadWrite    (loadWrite),
    .ctrlWrite    (ctrlWrite)
  );

  chain_timer_dp #(.HALF_W(HALF_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .loadVal  (loadVal),
    .countVal (countVal),
    .cntZero  (cntZero)
  );

endmodule

// File: rtl/chain_timer_chk.sv
module chain_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              stall,
  input logic [2:0]        cfgSel,
  input logic              periodic,
  input logic              rawBit,
  input logic              maskBit,
  input logic              timeout,
  input logic              loadWrite,
  input logic              ctrlWrite,
  input logic              clearReq,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] loadVal,
  input logic              irq,
  input logic              trigOut
);

  // R4
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !stall && cfgSel == 3'd0 && countVal != '0 && !loadWrite)
      |=> countVal == $past(countVal) - DATA_W'(1));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !loadWrite) |=> countVal == loadVal);

  // R5
  periodic_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && periodic && !ctrlWrite) |=> run);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !periodic && !ctrlWrite) |=> !run);

  // R8
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawBit && !clearReq) |=> rawBit);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawBit && maskBit));

  // R10
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (run && !stall && countVal == '0));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && stall && !loadWrite && !ctrlWrite) |=> $stable(countVal));

  // R13
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel != 3'd0 && !loadWrite && !ctrlWrite) |=> $stable(countVal));

endmodule

bind chain_timer chain_timer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .run       (runBit),
  .stall     (stallBit),
  .cfgSel    (cfgSel),
  .periodic  (periodicMode),
  .rawBit    (rawBit),
  .maskBit   (maskBit),
  .timeout   (timeoutEvt),
  .loadWrite (loadWrite),
  .ctrlWrite (ctrlWrite),
  .clearReq  (wrEn && (int'(addr) == 11) && wrData[0]),
  .countVal  (countVal),
  .loadVal   (loadVal),
  .irq       (irq),
  .trigOut   (trigOut)
);

// File: tb/chain_timer_tb_top.sv
module chain_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  logic        trigOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state, derived from the requirements
  logic [31:0] mLoad, mCnt;
  logic [2:0]  mCfg;
  logic [1:0]  mModeLo, mModeHi;
  logic        mRun, mStall, mTrigEn, mRaw, mMask;

  always #5 clk = ~clk;

  chain_timer dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .irq     (irq),
    .trigOut (trigOut)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int a);
    logic [31:0] v;
    v = '0;
    case (a)
      0:  v[2:0]  = mCfg;
      1:  v[1:0]  = mModeLo;
      2:  v[1:0]  = mModeHi;
      3:  v[2:0]  = {mTrigEn, mStall, mRun};
      4:  v       = mLoad;
      5:  v[15:0] = mLoad[31:16];
      6:  v       = mCnt;
      7:  v[15:0] = mCnt[31:16];
      8:  v[0]    = mRaw;
      9:  v[0]    = mMask;
      10: v[0]    = mRaw & mMask;
      default: v  = '0;
    endcase
    return v;
  endfunction

  function automatic string tagFor(input int a);
    case (a)
      0:  return "R13";
      1:  return "R5";
      2:  return "R7";
      3:  return "R6";
      4, 5: return "R2";
      6, 7: return "R3";
      8:  return "R8";
      9, 10: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic expTimeout();
    return mRun && !mStall && (mCfg == 3'd0) && (mCnt == 32'd0);
  endfunction

  // One clock cycle: drive at negedge, check, advance the reference at posedge
  task automatic cyc(input logic w, input int a, input logic [31:0] d,
                     input string tag = "");
    logic        to;
    logic        loadWr;
    logic [31:0] nLoad;
    wrEn = w; addr = 4'(a); wrData = d;
    #1;
    to = expTimeout();
    check("R9", "irq", {31'b0, irq}, {31'b0, mRaw & mMask});
    check(mLoad == 32'd0 ? "R14" : "R10", "trigOut",
          {31'b0, trigOut}, {31'b0, to & mTrigEn});
    if (!w) check(tag == "" ? tagFor(a) : tag, $sformatf("read@%0d", a),
                  rdData, expRead(a));
    @(posedge clk);
    loadWr = w && (a == 4 || a == 5);
    nLoad  = mLoad;
    if (w && a == 4) nLoad = d;
    if (w && a == 5) nLoad = {d[15:0], mLoad[15:0]};
    if ((w && a == 3 && d[0] && !mRun) || (mRun && loadWr) || to) mCnt = nLoad;
    else if (mRun && !mStall && mCfg == 3'd0) mCnt = mCnt - 32'd1;
    mLoad = nLoad;
    if (w && a == 3) begin
      mRun = d[0]; mStall = d[1]; mTrigEn = d[2];
    end else if (to && mModeLo != 2'd2) begin
      mRun = 1'b0;
    end
    mRaw = ((w && a == 11 && d[0]) ? 1'b0 : mRaw) | to;
    if (w && a == 0) mCfg = d[2:0];
    if (w && a == 1) mModeLo = d[1:0];
    if (w && a == 2) mModeHi = d[1:0];
    if (w && a == 9) mMask = d[0];
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int a, input string tag = "");
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0, tag);
  endtask

  function automatic logic [31:0] randData(input int a);
    int r;
    r = int'($urandom % 100);
    case (a)
      0: return (r < 6) ? 32'(1 + $urandom % 7) : 32'd0;
      3: return (r < 70) ? 32'(($urandom % 8) | 1) : 32'($urandom % 8);
      4: return (r < 5) ? 32'd0 : 32'($urandom % 24);
      5: return 32'd0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd5171));
    mLoad = '1; mCnt = '1; mCfg = '0; mModeLo = '0; mModeHi = '0;
    mRun = 0; mStall = 0; mTrigEn = 0; mRaw = 0; mMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every offset
    for (int a = 0; a < 16; a++) cyc(1'b0, a, 32'd0, "R1");

    // R2: full and upper-half interval writes
    cyc(1'b1, 4, 32'h0001_0002);
    cyc(1'b0, 4, 0, "R2"); cyc(1'b0, 5, 0, "R2");
    cyc(1'b1, 5, 32'hABCD_0003);
    cyc(1'b0, 4, 0, "R2"); cyc(1'b0, 5, 0, "R2");
    cyc(1'b0, 6, 0, "R11");  // idle write left count untouched
    cyc(1'b1, 4, 32'h0001_0002);

    // R4 / R3: start, borrow across the halves
    cyc(1'b1, 9, 32'd1);
    cyc(1'b1, 1, 32'd2);
    cyc(1'b1, 3, 32'd5);
    idle(4, 6, "R4");
    idle(2, 7, "R3");

    // R11: rewrite while running
    cyc(1'b1, 4, 32'd5);
    idle(2, 6, "R11");
    // R5 / R10: periodic timeouts, pulses and irq
    idle(20, 6, "R5");
    cyc(1'b0, 3, 0, "R5");
    // R8: clear with 0 then 1
    cyc(1'b1, 11, 32'd0);
    cyc(1'b0, 8, 0, "R8");
    cyc(1'b1, 11, 32'd1);
    cyc(1'b0, 8, 0, "R8");
    cyc(1'b0, 10, 0, "R9");

    // R12: stall holds the count
    cyc(1'b1, 3, 32'd7);
    idle(10, 6, "R12");
    cyc(1'b1, 4, 32'd3);
    idle(3, 6, "R12");
    cyc(1'b1, 3, 32'd5);
    idle(6, 6, "R12");

    // R6 / R7: one-shot, upper mode ignored
    cyc(1'b1, 3, 32'd0);
    cyc(1'b1, 2, 32'd2);
    cyc(1'b1, 1, 32'd1);
    cyc(1'b1, 4, 32'd3);
    cyc(1'b1, 3, 32'd5);
    idle(8, 3, "R6");
    idle(3, 6, "R7");
    cyc(1'b0, 2, 0, "R7");

    // R13: reserved config freezes
    cyc(1'b1, 0, 32'd1);
    cyc(1'b1, 3, 32'd1);
    idle(5, 6, "R13");
    cyc(1'b0, 0, 0, "R13");
    cyc(1'b1, 0, 32'd0);
    idle(3, 6, "R13");

    // R14: zero interval, periodic
    cyc(1'b1, 3, 32'd0);
    cyc(1'b1, 1, 32'd2);
    cyc(1'b1, 4, 32'd0);
    cyc(1'b1, 3, 32'd5);
    idle(6, 6, "R14");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 100 < 22) begin
        int a;
        a = int'($urandom % 12);
        if (a == 6 || a == 7 || a == 10) a = 11;
        cyc(1'b1, a, randData(a));
      end else begin
        cyc(1'b0, int'($urandom % 16), 32'd0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule